// File: doc/BRIEF.md
# DRAM Row-Buffer Hit Classifier

This block watches an already decoded command stream for one rank of a DDR4 device and classifies every column access by the state of its bank's row buffer. For each of the rank's banks it records whether a row is open and whether that row has been accessed since it was activated. From that record, each read or write counts as a miss when it is the first access after the activate, and as a hit when it reaches a row that an earlier access has already used. A row that is closed without ever being accessed counts as unused.

Counts are kept per bank, with reads and writes held apart. All counts saturate. A single-cycle interval-end pulse copies every live count into a snapshot register and clears the live count. A performance monitor can then read a stable set of figures for each measurement window while the next window accumulates. Commands that break the open/closed protocol of a bank are reported on an error pulse and are never counted.

Top module: `page_hit_classifier`

## Requirements
- R1: The first read (type 1) or write (type 2) to a bank after an activate (type 0) opened it adds one to that bank's read-miss or write-miss count.
- R2: Any later read or write to the same open row adds one to that bank's read-hit or write-hit count.
- R3: A precharge (type 3) to an open bank closes it. If no access reached the row since its activate, the bank's unused count rises by one. A precharge to a closed bank has no effect.
- R4: A precharge-all (type 4) closes every open bank in one cycle. Each bank closed untouched adds one to its own unused count.
- R5: Banks are tracked independently (bank number on `cmd_bank`), and read and write counts never mix.
- R6: A read or write to a closed bank raises `proto_err` for exactly the cycle after the command. Nothing is counted and no bank state changes.
- R7: An activate to a bank that is already open raises `proto_err` and leaves that bank's row and access history unchanged.
- R8: A refresh (type 5) while any bank is open raises `proto_err`. A refresh with all banks closed has no effect.
- R9: Every count stops at 2^CNT_W-1 and does not wrap.
- R10: On `interval_end` each snapshot takes its live count, including the command presented in the same cycle, and the live count restarts from zero. Bank state is kept across the boundary, and snapshots do not change at any other time.
- R11: A command with `cmd_valid` low, or with type 6 or 7, has no effect on any count, state or error.
- R12: After reset all snapshots are zero, all banks are closed and `proto_err` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_type | input | 3 | 0 activate, 1 read, 2 write, 3 precharge, 4 precharge-all, 5 refresh |
| cmd_bank | input | BANK_W (4) | Target bank of the command |
| interval_end | input | 1 | Ends the measurement window; latch snapshots |
| snap_rd_hit | output | NBANK*CNT_W | Read-hit snapshot, bank b at bits [b*CNT_W +: CNT_W] |
| snap_rd_miss | output | NBANK*CNT_W | Read-miss snapshot, same packing |
| snap_wr_hit | output | NBANK*CNT_W | Write-hit snapshot, same packing |
| snap_wr_miss | output | NBANK*CNT_W | Write-miss snapshot, same packing |
| snap_unused | output | NBANK*CNT_W | Unused-row snapshot, same packing |
| proto_err | output | 1 | Protocol violation seen on the previous cycle's command |

## Verification
Errors in the per-bank open or touched flags do not show at once. They surface as a hit counted where a miss is due, as a missing or extra unused count, or as a false `proto_err`. The counts become visible only at the next `interval_end`, while the error pulse appears one cycle after the command. The bench therefore compares every snapshot field at each interval boundary and checks the error pulse after every command. Short windows bound the delay between a fault and its report. A fault in saturation or in the clear on snapshot shows as a wrong count in the window that follows.

// File: rtl/phc_pkg.sv
package phc_pkg;
   typedef enum logic [2:0] {
      CMD_ACT  = 3'd0,
      CMD_RD   = 3'd1,
      CMD_WR   = 3'd2,
      CMD_PRE  = 3'd3,
      CMD_PREA = 3'd4,
      CMD_REF  = 3'd5
   } phc_cmd_e;

   localparam int NKIND   = 5;
   localparam int K_RDHIT = 0;
   localparam int K_RDMIS = 1;
   localparam int K_WRHIT = 2;
   localparam int K_WRMIS = 3;
   localparam int K_UNUSD = 4;
endpackage

// File: rtl/phc_bank_tracker.sv
module phc_bank_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic do_act,
   input  logic do_rd,
   input  logic do_wr,
   input  logic do_pre,
   input  logic do_prea,
   output logic is_open,
   output logic ev_rd_hit,
   output logic ev_rd_miss,
   output logic ev_wr_hit,
   output logic ev_wr_miss,
   output logic ev_unused,
   output logic err_access,
   output logic err_act
);
   logic touched;
   logic acc, closing, opening;

   always_comb begin
      acc        = sel & (do_rd | do_wr);
      opening    = sel & do_act & ~is_open;
      closing    = is_open & ((sel & do_pre) | do_prea);
      ev_rd_hit  = sel & do_rd & is_open & touched;
      ev_rd_miss = sel & do_rd & is_open & ~touched;
      ev_wr_hit  = sel & do_wr & is_open & touched;
      ev_wr_miss = sel & do_wr & is_open & ~touched;
      ev_unused  = closing & ~touched;
      err_access = acc & ~is_open;
      err_act    = sel & do_act & is_open;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         touched <= 1'b0;
      end else if (opening) begin
         is_open <= 1'b1;
         touched <= 1'b0;
      end else if (closing) begin
         is_open <= 1'b0;
      end else if (acc && is_open) begin
         touched <= 1'b1;
      end
   end
endmodule

// File: rtl/phc_sat_counter.sv
module phc_sat_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             latch,
   output logic [CNT_W-1:0] snap
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] live, live_nxt;

   always_comb begin
      live_nxt = live;
      if (inc && live != CMAX) live_nxt = live + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live <= '0;
         snap <= '0;
      end else if (latch) begin
         snap <= live_nxt;
         live <= '0;
      end else begin
         live <= live_nxt;
      end
   end
endmodule

// File: rtl/page_hit_classifier.sv
module page_hit_classifier
   import phc_pkg::*;
#(
   parameter int NBANK  = 16,
   parameter int CNT_W  = 16,
   parameter int BANK_W = $clog2(NBANK)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   input  logic [2:0]             cmd_type,
   input  logic [BANK_W-1:0]      cmd_bank,
   input  logic                   interval_end,
   output logic [NBANK*CNT_W-1:0] snap_rd_hit,
   output logic [NBANK*CNT_W-1:0] snap_rd_miss,
   output logic [NBANK*CNT_W-1:0] snap_wr_hit,
   output logic [NBANK*CNT_W-1:0] snap_wr_miss,
   output logic [NBANK*CNT_W-1:0] snap_unused,
   output logic                   proto_err
);
   localparam int SNAP_W = NBANK * CNT_W;

   generate
      if (NBANK < 2 || (1 << BANK_W) != NBANK) begin : g_bad_nbank
         $error("NBANK must be a power of two of at least 2");
      end
      if (CNT_W < 2) begin : g_bad_cntw
         $error("CNT_W must be at least 2");
      end
   endgenerate

   logic do_act, do_rd, do_wr, do_pre, do_prea, do_ref;
   always_comb begin
      do_act  = cmd_valid && (cmd_type == CMD_ACT);
      do_rd   = cmd_valid && (cmd_type == CMD_RD);
      do_wr   = cmd_valid && (cmd_type == CMD_WR);
      do_pre  = cmd_valid && (cmd_type == CMD_PRE);
      do_prea = cmd_valid && (cmd_type == CMD_PREA);
      do_ref  = cmd_valid && (cmd_type == CMD_REF);
   end

   logic [NBANK-1:0] bank_open, err_acc_v, err_act_v;
   logic [NBANK-1:0] ev_rd_hit, ev_rd_miss, ev_wr_hit, ev_wr_miss, ev_unused;
   logic [NBANK-1:0] ev_kind [NKIND];
   logic [SNAP_W-1:0] snap_kind [NKIND];

   always_comb begin
      ev_kind[K_RDHIT] = ev_rd_hit;
      ev_kind[K_RDMIS] = ev_rd_miss;
      ev_kind[K_WRHIT] = ev_wr_hit;
      ev_kind[K_WRMIS] = ev_wr_miss;
      ev_kind[K_UNUSD] = ev_unused;
   end

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         phc_bank_tracker u_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (cmd_bank == BANK_W'(b)),
            .do_act     (do_act),
            .do_rd      (do_rd),
            .do_wr      (do_wr),
            .do_pre     (do_pre),
            .do_prea    (do_prea),
            .is_open    (bank_open[b]),
            .ev_rd_hit  (ev_rd_hit[b]),
            .ev_rd_miss (ev_rd_miss[b]),
            .ev_wr_hit  (ev_wr_hit[b]),
            .ev_wr_miss (ev_wr_miss[b]),
            .ev_unused  (ev_unused[b]),
            .err_access (err_acc_v[b]),
            .err_act    (err_act_v[b])
         );
         for (genvar k = 0; k < NKIND; k++) begin : g_kind
            phc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
               .clk   (clk),
               .rst_n (rst_n),
               .inc   (ev_kind[k][b]),
               .latch (interval_end),
               .snap  (snap_kind[k][b*CNT_W +: CNT_W])
            );
         end
      end
   endgenerate

   assign snap_rd_hit  = snap_kind[K_RDHIT];
   assign snap_rd_miss = snap_kind[K_RDMIS];
   assign snap_wr_hit  = snap_kind[K_WRHIT];
   assign snap_wr_miss = snap_kind[K_WRMIS];
   assign snap_unused  = snap_kind[K_UNUSD];

   logic ref_err;
   assign ref_err = do_ref && (|bank_open);

   always_ff @(posedge clk) begin
      if (!rst_n) proto_err <= 1'b0;
      else        proto_err <= (|err_acc_v) | (|err_act_v) | ref_err;
   end
endmodule

// File: rtl/phc_checker.sv
module phc_checker #(
   parameter int NBANK = 16,
   parameter int CNT_W = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cmd_valid,
   input logic [2:0]             cmd_type,
   input logic                   interval_end,
   input logic [NBANK*CNT_W-1:0] snap_rd_hit,
   input logic [NBANK*CNT_W-1:0] snap_unused,
   input logic                   proto_err,
   input logic [NBANK-1:0]       ev_rd_hit,
   input logic [NBANK-1:0]       ev_rd_miss,
   input logic [NBANK-1:0]       ev_wr_hit,
   input logic [NBANK-1:0]       ev_wr_miss,
   input logic [NBANK-1:0]       ev_unused
);
   assert_err_follows_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> $past(cmd_valid));

   assert_err_not_on_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> ($past(cmd_type) <= 3'd2 || $past(cmd_type) == 3'd5));

   assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(interval_end) |-> ($stable(snap_rd_hit) && $stable(snap_unused)));

   assert_one_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ev_rd_hit | ev_rd_miss | ev_wr_hit | ev_wr_miss));

   assert_rd_wr_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({|(ev_rd_hit | ev_rd_miss), |(ev_wr_hit | ev_wr_miss)}) <= 1);

   assert_unused_on_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_unused) |-> (cmd_valid && (cmd_type == 3'd3 || cmd_type == 3'd4)));

   assert_single_unused_pre_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_type == 3'd3) |-> $onehot0(ev_unused));
endmodule

bind page_hit_classifier phc_checker #(.NBANK(NBANK), .CNT_W(CNT_W)) u_phc_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid    (cmd_valid),
   .cmd_type     (cmd_type),
   .interval_end (interval_end),
   .snap_rd_hit  (snap_rd_hit),
   .snap_unused  (snap_unused),
   .proto_err    (proto_err),
   .ev_rd_hit    (ev_rd_hit),
   .ev_rd_miss   (ev_rd_miss),
   .ev_wr_hit    (ev_wr_hit),
   .ev_wr_miss   (ev_wr_miss),
   .ev_unused    (ev_unused)
);

// File: tb/page_hit_classifier_bench.sv
module page_hit_classifier_bench;
   localparam int NB   = 16;
   localparam int CW   = 4;
   localparam int MAXC = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_type = 3'd0;
   logic [3:0] cmd_bank = 4'd0;
   logic interval_end = 1'b0;
   logic [NB*CW-1:0] s_rh, s_rm, s_wh, s_wm, s_un;
   logic proto_err;

   page_hit_classifier #(.NBANK(NB), .CNT_W(CW)) u_page_hit_classifier (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
      .cmd_bank(cmd_bank), .interval_end(interval_end),
      .snap_rd_hit(s_rh), .snap_rd_miss(s_rm), .snap_wr_hit(s_wh),
      .snap_wr_miss(s_wm), .snap_unused(s_un), .proto_err(proto_err));

   always #4 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit m_open [NB];
   bit m_touch [NB];
   int m_live [5][NB];
   int m_snap [5][NB];
   bit exp_err;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_chk = n_chk + 1;
         n_fail = n_fail + 1;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   function automatic int got(int k, int b);
      case (k)
         0: return int'(s_rh[b*CW +: CW]);
         1: return int'(s_rm[b*CW +: CW]);
         2: return int'(s_wh[b*CW +: CW]);
         3: return int'(s_wm[b*CW +: CW]);
         default: return int'(s_un[b*CW +: CW]);
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk = n_chk + 1;
      if (act != exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic void bump(int k, int b);
      if (m_live[k][b] < MAXC) m_live[k][b] = m_live[k][b] + 1;
   endfunction

   function automatic void model(bit v, int t, int b, bit ie);
      bit any_open = 1'b0;
      exp_err = 1'b0;
      for (int i = 0; i < NB; i++) any_open |= m_open[i];
      if (v) begin
         case (t)
            0: if (m_open[b]) exp_err = 1'b1;
               else begin m_open[b] = 1'b1; m_touch[b] = 1'b0; end
            1, 2: if (!m_open[b]) exp_err = 1'b1;
               else begin
                  bump((t == 1 ? 0 : 2) + (m_touch[b] ? 0 : 1), b);
                  m_touch[b] = 1'b1;
               end
            3: if (m_open[b]) begin
                  if (!m_touch[b]) bump(4, b);
                  m_open[b] = 1'b0;
               end
            4: for (int i = 0; i < NB; i++)
                  if (m_open[i]) begin
                     if (!m_touch[i]) bump(4, i);
                     m_open[i] = 1'b0;
                  end
            5: if (any_open) exp_err = 1'b1;
            default: ;
         endcase
      end
      if (ie)
         for (int k = 0; k < 5; k++)
            for (int i = 0; i < NB; i++) begin
               m_snap[k][i] = m_live[k][i];
               m_live[k][i] = 0;
            end
   endfunction

   task automatic snaps(input string tag);
      for (int k = 0; k < 5; k++)
         for (int i = 0; i < NB; i++)
            check($sformatf("%s snap kind%0d bank%0d", tag, k, i), got(k, i), m_snap[k][i]);
   endtask

   task automatic cmd(input bit v, input int t, input int b, input bit ie, input string tag);
      @(negedge clk);
      cmd_valid = v; cmd_type = t[2:0]; cmd_bank = b[3:0]; interval_end = ie;
      @(posedge clk); #1;
      model(v, t, b, ie);
      check({tag, " proto_err"}, int'(proto_err), int'(exp_err));
      if (ie) snaps(tag);
   endtask

   initial begin
      void'($urandom(32'd2718));
      for (int k = 0; k < 5; k++)
         for (int i = 0; i < NB; i++) begin m_live[k][i] = 0; m_snap[k][i] = 0; end
      for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_touch[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      check("R12 proto_err at reset", int'(proto_err), 0);
      snaps("R12");
      // R1 R2: miss then hits
      cmd(1, 0, 3, 0, "R1");
      cmd(1, 1, 3, 0, "R1");
      cmd(1, 1, 3, 0, "R2");
      cmd(1, 2, 3, 0, "R2");
      cmd(0, 0, 0, 1, "R1 R2");
      // R3: unused on precharge, closed precharge ignored
      cmd(1, 3, 3, 0, "R3");
      cmd(1, 0, 5, 0, "R3");
      cmd(1, 3, 5, 0, "R3");
      cmd(1, 3, 5, 0, "R3");
      cmd(1, 0, 6, 0, "R3");
      cmd(1, 2, 6, 0, "R3");
      cmd(1, 3, 6, 1, "R3");
      // R4: precharge-all
      cmd(1, 0, 0, 0, "R4");
      cmd(1, 0, 1, 0, "R4");
      cmd(1, 0, 15, 0, "R4");
      cmd(1, 1, 1, 0, "R4");
      cmd(1, 4, 0, 1, "R4");
      // R6: access to closed bank
      cmd(1, 1, 9, 0, "R6");
      cmd(1, 2, 9, 1, "R6");
      // R7: activate to open bank keeps history
      cmd(1, 0, 4, 0, "R7");
      cmd(1, 2, 4, 0, "R7");
      cmd(1, 0, 4, 0, "R7");
      cmd(1, 2, 4, 1, "R7");
      // R8: refresh rules
      cmd(1, 5, 4, 0, "R8");
      cmd(1, 4, 0, 0, "R8");
      cmd(1, 5, 4, 1, "R8");
      // R11: invalid and reserved codes
      cmd(1, 0, 7, 0, "R11");
      cmd(0, 1, 7, 0, "R11");
      cmd(1, 6, 7, 0, "R11");
      cmd(1, 7, 7, 0, "R11");
      cmd(0, 3, 7, 0, "R11");
      cmd(1, 1, 7, 1, "R11");
      // R9: saturation
      cmd(1, 0, 2, 0, "R9");
      for (int i = 0; i < 20; i++) cmd(1, 1, 2, 0, "R9");
      cmd(0, 0, 0, 1, "R9");
      // R10: boundary event lands in snapshot, live restarts, state kept
      cmd(1, 1, 2, 1, "R10");
      cmd(1, 2, 2, 0, "R10");
      cmd(0, 0, 0, 1, "R10");
      cmd(1, 4, 0, 1, "R10");
      // R5: random traffic across banks and directions
      for (int n = 0; n < 3000; n++) begin
         int r = int'($urandom % 100);
         int t;
         int b = int'($urandom % NB);
         bit v = 1'b1;
         if (r < 22) t = 0;
         else if (r < 47) t = 1;
         else if (r < 67) t = 2;
         else if (r < 86) t = 3;
         else if (r < 90) t = 4;
         else if (r < 94) t = 5;
         else if (r < 97) t = 6 + int'($urandom % 2);
         else begin t = int'($urandom % 6); v = 1'b0; end
         cmd(v, t, b, ($urandom % 40) == 0, "R5");
      end
      cmd(1, 4, 0, 1, "R5");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule